// File: doc/BRIEF.md
# Segment access protection checker

This block takes one memory access and the cached descriptor of the segment it goes through. It returns either the linear address of the access or a fault. The access is described by its offset, its size in bytes and its kind, which is an instruction fetch, a data read or a data write. The descriptor supplies the base, the limit, the present bit, the executable bit, the read/write bit, the descriptor privilege level (DPL) and the requested privilege level (RPL) of the selector. The caller also supplies the current privilege level (CPL) and a protected-mode enable bit.

A request strobe starts a check. One cycle later the block gives a single-cycle valid pulse with the result: either the linear address, or a fault flag and a fault kind. The fault kind is either general protection or segment-not-present. The checks run in a fixed priority order: limit, present, privilege, type. Only the first fault found is reported. In real mode only the limit check applies. Descriptor loading, paging and the memory transaction itself belong to other blocks.

Top module: `seg_access_chk`

## Requirements
- R1: When the 33-bit sum offset + size − 1 is greater than the limit, the block raises a general-protection fault (kind 0). This check applies in both modes and takes priority over all other checks.
- R2: When the protection enable input is low, any access that passes the limit check succeeds, whatever the descriptor attribute fields hold.
- R3: In protected mode, a segment whose present bit is clear raises a not-present fault (kind 1). This check ranks above the privilege and type checks.
- R4: In protected mode, a CPL numerically greater than DPL raises a general-protection fault for every access kind.
- R5: In protected mode, an RPL greater than DPL raises a general-protection fault for data reads and data writes. For instruction fetches (kind code 0) RPL is not tested.
- R6: In protected mode, an instruction fetch from a segment whose executable bit is clear raises a general-protection fault.
- R7: In protected mode, a data read (kind code 1) from a segment that is executable and has its read/write bit clear raises a general-protection fault.
- R8: In protected mode, a data write (kind code 2) raises a general-protection fault when the segment is executable, or when the read/write bit is clear.
- R9: On success the linear address is base + offset, taken modulo 2^ADDR_W, and the fault flag is low.
- R10: The valid output is high for exactly one cycle, in the cycle after a request strobe is sampled. After reset it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request strobe |
| offset_i | input | ADDR_W | Access offset within the segment |
| size_i | input | SIZE_W | Access size in bytes (at least 1) |
| kind_i | input | 2 | Access kind: 0 fetch, 1 read, 2 write |
| base_i | input | ADDR_W | Segment base |
| limit_i | input | ADDR_W | Segment limit (last valid offset) |
| present_i | input | 1 | Descriptor present bit |
| exec_i | input | 1 | Descriptor executable bit |
| rw_i | input | 1 | Read/write bit: readable for code, writable for data |
| dpl_i | input | 2 | Descriptor privilege level |
| rpl_i | input | 2 | Selector requested privilege level |
| cpl_i | input | 2 | Current privilege level |
| pe_i | input | 1 | Protected-mode enable |
| valid_o | output | 1 | Result valid, one-cycle pulse |
| lin_addr_o | output | ADDR_W | Linear address, valid on success |
| fault_o | output | 1 | Fault detected |
| fault_kind_o | output | 1 | Fault kind: 0 general protection, 1 not present |

## Verification
The bench uses the defaults ADDR_W = 32 and SIZE_W = 3. With a full 32-bit offset, an access that ends at 0xFFFFFFFF and a large offset whose end would wrap past 2^32 are both reachable, so the 33-bit limit compare and the modulo base addition are exercised at their true edges. A 3-bit size field covers accesses of 1, 2 and 4 bytes, so a single-byte access that ends exactly on the limit and a multi-byte access that crosses it are both tested. The priority cases each combine two faults, to show which one is reported.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;
  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_READ  = 2'd1,
    ACC_WRITE = 2'd2
  } acc_kind_e;

  typedef enum logic {
    FLT_GP = 1'b0,
    FLT_NP = 1'b1
  } flt_kind_e;

  typedef struct packed {
    logic      fault;
    flt_kind_e kind;
  } chk_res_t;
endpackage

// File: rtl/seg_limit_chk.sv
module seg_limit_chk #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 3
) (
  input  logic [ADDR_W-1:0] offset_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [ADDR_W-1:0] limit_i,
  output logic              over_o
);
  localparam int EXT_W = ADDR_W + 1;
  logic [EXT_W-1:0] last_byte;

  // widened so the end of the access cannot wrap below the limit
  always_comb begin
    last_byte = EXT_W'(offset_i) + EXT_W'(size_i) - EXT_W'(1);
    over_o    = last_byte > EXT_W'(limit_i);
  end
endmodule

// File: rtl/seg_prot_chk.sv
module seg_prot_chk
  import seg_chk_pkg::*;
(
  input  logic [1:0] kind_i,
  input  logic       present_i,
  input  logic       exec_i,
  input  logic       rw_i,
  input  logic [1:0] dpl_i,
  input  logic [1:0] rpl_i,
  input  logic [1:0] cpl_i,
  output chk_res_t   res_o
);
  logic is_fetch, is_read, is_write;
  logic priv_bad, type_bad;

  always_comb begin
    is_fetch = kind_i == ACC_FETCH;
    is_read  = kind_i == ACC_READ;
    is_write = kind_i == ACC_WRITE;

    priv_bad = (cpl_i > dpl_i) || (!is_fetch && (rpl_i > dpl_i));

    type_bad = 1'b0;
    if (is_fetch)      type_bad = !exec_i;
    else if (is_read)  type_bad = exec_i && !rw_i;
    else if (is_write) type_bad = exec_i || !rw_i;

    res_o = '{fault: 1'b0, kind: FLT_GP};
    if (!present_i)    res_o = '{fault: 1'b1, kind: FLT_NP};
    else if (priv_bad) res_o = '{fault: 1'b1, kind: FLT_GP};
    else if (type_bad) res_o = '{fault: 1'b1, kind: FLT_GP};
  end
endmodule

// File: rtl/seg_access_chk.sv
module seg_access_chk
  import seg_chk_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] offset_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [1:0]        kind_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] limit_i,
  input  logic              present_i,
  input  logic              exec_i,
  input  logic              rw_i,
  input  logic [1:0]        dpl_i,
  input  logic [1:0]        rpl_i,
  input  logic [1:0]        cpl_i,
  input  logic              pe_i,
  output logic              valid_o,
  output logic [ADDR_W-1:0] lin_addr_o,
  output logic              fault_o,
  output logic              fault_kind_o
);
  logic     over_lim;
  chk_res_t prot_res, final_res;

  seg_limit_chk #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_lim (
    .offset_i (offset_i),
    .size_i   (size_i),
    .limit_i  (limit_i),
    .over_o   (over_lim)
  );

  seg_prot_chk u_prot (
    .kind_i    (kind_i),
    .present_i (present_i),
    .exec_i    (exec_i),
    .rw_i      (rw_i),
    .dpl_i     (dpl_i),
    .rpl_i     (rpl_i),
    .cpl_i     (cpl_i),
    .res_o     (prot_res)
  );

  always_comb begin
    if (over_lim)   final_res = '{fault: 1'b1, kind: FLT_GP};
    else if (pe_i)  final_res = prot_res;
    else            final_res = '{fault: 1'b0, kind: FLT_GP};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o      <= 1'b0;
      lin_addr_o   <= '0;
      fault_o      <= 1'b0;
      fault_kind_o <= 1'b0;
    end else begin
      valid_o <= req_i;
      if (req_i) begin
        lin_addr_o   <= base_i + offset_i;
        fault_o      <= final_res.fault;
        fault_kind_o <= final_res.kind;
      end
    end
  end
endmodule

// File: rtl/seg_access_chk_sva.sv
module seg_access_chk_sva #(
  parameter int ADDR_W = 32,
  parameter int SIZE_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic [ADDR_W-1:0] offset_i,
  input logic [SIZE_W-1:0] size_i,
  input logic [1:0]        kind_i,
  input logic [ADDR_W-1:0] base_i,
  input logic [ADDR_W-1:0] limit_i,
  input logic              present_i,
  input logic [1:0]        dpl_i,
  input logic [1:0]        cpl_i,
  input logic              pe_i,
  input logic              valid_o,
  input logic [ADDR_W-1:0] lin_addr_o,
  input logic              fault_o,
  input logic              fault_kind_o
);
  logic [ADDR_W:0] end_x;
  assign end_x = {1'b0, offset_i} + {{(ADDR_W+1-SIZE_W){1'b0}}, size_i} - 1'b1;

  assert_valid_follows_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> valid_o);
  assert_valid_needs_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !valid_o);
  assert_limit_gp_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && size_i != '0 && end_x > {1'b0, limit_i}) |=> (fault_o && !fault_kind_o));
  assert_real_mode_ok_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !pe_i && size_i != '0 && end_x <= {1'b0, limit_i}) |=> !fault_o);
  assert_not_present_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && pe_i && !present_i && size_i != '0 && end_x <= {1'b0, limit_i})
      |=> (fault_o && fault_kind_o));
  assert_cpl_gp_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && pe_i && present_i && cpl_i > dpl_i) |=> (fault_o && !fault_kind_o));
  assert_lin_addr_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> lin_addr_o == $past(base_i) + $past(offset_i));
  assert_np_only_pe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !pe_i) |=> !fault_kind_o);
endmodule

bind seg_access_chk seg_access_chk_sva #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .offset_i(offset_i), .size_i(size_i),
  .kind_i(kind_i), .base_i(base_i), .limit_i(limit_i), .present_i(present_i),
  .dpl_i(dpl_i), .cpl_i(cpl_i), .pe_i(pe_i), .valid_o(valid_o),
  .lin_addr_o(lin_addr_o), .fault_o(fault_o), .fault_kind_o(fault_kind_o)
);

// File: tb/tb_seg_access_chk.sv
`timescale 1ns/1ps
module tb_seg_access_chk;
  localparam int ADDR_W = 32;
  localparam int SIZE_W = 3;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              req_i = 1'b0;
  logic [ADDR_W-1:0] offset_i = '0, base_i = '0, limit_i = '0;
  logic [SIZE_W-1:0] size_i = 3'd1;
  logic [1:0]        kind_i = '0, dpl_i = '0, rpl_i = '0, cpl_i = '0;
  logic              present_i = 1'b1, exec_i = 1'b0, rw_i = 1'b1, pe_i = 1'b0;
  logic              valid_o, fault_o, fault_kind_o;
  logic [ADDR_W-1:0] lin_addr_o;

  typedef struct {
    logic        fault;
    logic        kind;
    logic [31:0] addr;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #4 clk_i = ~clk_i;

  seg_access_chk #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) dut (.*);

  task automatic drive(input logic [31:0] off, input logic [2:0] sz, input logic [1:0] knd,
                       input logic [31:0] bs, input logic [31:0] lim, input logic pr,
                       input logic ex, input logic rw, input logic [1:0] dpl,
                       input logic [1:0] rpl, input logic [1:0] cpl, input logic pe,
                       input logic ef, input logic ek, input string tag);
    exp_t e;
    @(negedge clk_i);
    offset_i = off; size_i = sz; kind_i = knd; base_i = bs; limit_i = lim;
    present_i = pr; exec_i = ex; rw_i = rw; dpl_i = dpl; rpl_i = rpl; cpl_i = cpl;
    pe_i = pe; req_i = 1'b1;
    e.fault = ef; e.kind = ek; e.addr = bs + off; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk_i);
    req_i = 1'b0;
  endtask

  // monitor: sample at negedge, after the registered result settles
  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      exp_t e;
      n_vec++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R10 unexpected valid act=1 exp=0");
      end else begin
        e = exp_q.pop_front();
        if (fault_o !== e.fault || (e.fault && fault_kind_o !== e.kind) ||
            (!e.fault && lin_addr_o !== e.addr)) begin
          n_bad++;
          $display("FAIL %s act f=%0b k=%0b a=%h exp f=%0b k=%0b a=%h", e.tag,
                   fault_o, fault_kind_o, lin_addr_o, e.fault, e.kind, e.addr);
        end
      end
    end
  end

  initial begin
    #20000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #3;
    n_vec++;
    if (valid_o !== 1'b0) begin n_bad++; $display("FAIL R10 reset valid act=%b exp=0", valid_o); end
    #10 rst_ni = 1'b1;
    // R2 real mode, garbage attributes ignored
    drive(32'h10, 3'd4, 2'd2, 32'h1000, 32'hFF, 0, 1, 0, 0, 3, 3, 0, 0, 0, "R2 real ignore attrs");
    // R1 limit at exact edge and one over
    drive(32'hFF, 3'd1, 2'd1, 32'h0, 32'hFF, 1, 0, 1, 0, 0, 0, 0, 0, 0, "R1 edge pass");
    drive(32'hFE, 3'd4, 2'd1, 32'h0, 32'hFF, 1, 0, 1, 0, 0, 0, 0, 1, 0, "R1 cross limit");
    drive(32'hFFFFFFFE, 3'd4, 2'd1, 32'h0, 32'hFFFFFFFF, 1, 0, 1, 0, 0, 0, 1, 1, 0, "R1 wrap 33bit");
    drive(32'hFFFFFFFC, 3'd4, 2'd1, 32'h0, 32'hFFFFFFFF, 1, 0, 1, 0, 0, 0, 1, 0, 0, "R1 end at top");
    drive(32'h200, 3'd1, 2'd1, 32'h0, 32'h100, 0, 0, 1, 0, 0, 0, 1, 1, 0, "R1 beats not-present");
    // R3
    drive(32'h0, 3'd1, 2'd0, 32'h0, 32'hFF, 0, 1, 1, 0, 0, 3, 1, 1, 1, "R3 not present");
    // R4
    drive(32'h0, 3'd1, 2'd0, 32'h0, 32'hFF, 1, 1, 1, 1, 0, 2, 1, 1, 0, "R4 cpl>dpl fetch");
    // R5
    drive(32'h0, 3'd1, 2'd0, 32'h0, 32'hFF, 1, 1, 1, 1, 3, 1, 1, 0, 0, "R5 fetch ignores rpl");
    drive(32'h0, 3'd1, 2'd1, 32'h0, 32'hFF, 1, 0, 1, 1, 3, 1, 1, 1, 0, "R5 read rpl>dpl");
    drive(32'h0, 3'd1, 2'd2, 32'h0, 32'hFF, 1, 0, 1, 1, 2, 0, 1, 1, 0, "R5 write rpl>dpl");
    // R6
    drive(32'h0, 3'd1, 2'd0, 32'h0, 32'hFF, 1, 0, 1, 0, 0, 0, 1, 1, 0, "R6 fetch data seg");
    // R7
    drive(32'h0, 3'd1, 2'd1, 32'h0, 32'hFF, 1, 1, 0, 0, 0, 0, 1, 1, 0, "R7 read exec-only");
    drive(32'h4, 3'd2, 2'd1, 32'h500, 32'hFF, 1, 1, 1, 0, 0, 0, 1, 0, 0, "R7 read readable code");
    // R8
    drive(32'h0, 3'd1, 2'd2, 32'h0, 32'hFF, 1, 1, 1, 0, 0, 0, 1, 1, 0, "R8 write code");
    drive(32'h0, 3'd1, 2'd2, 32'h0, 32'hFF, 1, 0, 0, 0, 0, 0, 1, 1, 0, "R8 write read-only");
    // R9 success with modulo wrap
    drive(32'h20, 3'd4, 2'd2, 32'hFFFFFFF0, 32'hFFFF, 1, 0, 1, 3, 3, 3, 1, 0, 0, "R9 wrap add");
    repeat (3) @(negedge clk_i);
    n_vec++;
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R10 pending act=%0d exp=0", exp_q.size());
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule